// File: doc/BRIEF.md
# Periodic Wakeup Timer

This block is a slow interval timer meant to run from a low-speed oscillator of roughly 128 kHz. It produces a single-cycle wakeup strobe at a programmable period, so that a sleeping system can resume. Two stages set the period. A prescaler with a 4-bit, non-uniform code divides the clock into ticks. A small up-counter then counts those ticks until it reaches a programmed window value.

Software sets up the timer through a simple synchronous register port. There is one write strobe, a word address, write data, and read data that is combinational. Three fields are visible: an enable bit, the prescaler code and the window value. Clearing the enable holds the whole timer at zero. Setting it starts a fresh period. A change to the code or window while the timer runs is held back and applied when the counter next restarts, so the period in progress is never cut short.

Top module: `lp_wake_timer`

## Requirements
- R1: After reset the enable field reads 0, the window field reads 0x3F, the prescaler code reads 0, and `wake_o` is low.
- R2: The register fields sit at these word addresses. Address 0 holds the enable in bit 0. Address 1 holds the window in bits [5:0]. Address 2 holds the prescaler code in bits [3:0]. Every other bit, and every other address, reads 0 and ignores writes.
- R3: The prescaler divisor is set by the code. Codes 0 and 1 give 1. Codes 2 through 13 give 2^(code-1), that is 2 up to 4096. Code 14 gives 10240 and code 15 gives 61440.
- R4: Take a window W of 1 or more and a divisor D. The first strobe comes W·D clock edges after the edge that writes enable=1. Each later strobe comes (W+1)·D edges after the one before.
- R5: With window 0, a strobe comes every D edges, starting D edges after the enable write. With D=1 the output stays high on every cycle.
- R6: When the period is longer than one cycle, each strobe lasts exactly one clock cycle.
- R7: While the enable is 0, no strobe is produced. Writing 0 clears the prescaler and the counter, so enabling again starts a full period from zero.
- R8: A window or code write made while the timer is enabled does not affect the period in progress. The new value is first used from the counter restart that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (2) | Word address of the register |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data for `reg_addr_i`, combinational |
| wake_o | output | 1 | One-cycle wakeup strobe |

## Verification
If the prescaler or the counter held a wrong value, the strobe would come early or late. That error shows within one period and scales with the divisor, so strobe spacing is measured edge by edge for several codes and windows. If the shadowed configuration loaded at the wrong time, the first period after a write made while running would have the new length and not the old one. That shows within two strobes of the write. If the cleanup on disable were missing, the first strobe after re-enabling would come too early.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

   localparam int unsigned CODE_W = 4;
   localparam int unsigned DIV_W  = 16;

   // Code-to-divisor mapping: two bypass codes, a doubling run, two odd top codes.
   function automatic logic [DIV_W-1:0] lpw_divisor(input logic [CODE_W-1:0] code);
      logic [DIV_W-1:0] d;
      if (code <= CODE_W'(1))
         d = DIV_W'(1);
      else if (code == CODE_W'(14))
         d = DIV_W'(10240);
      else if (code == CODE_W'(15))
         d = DIV_W'(61440);
      else
         d = DIV_W'(1) << (code - CODE_W'(1));
      return d;
   endfunction

endpackage

// File: rtl/lpw_regs.sv
module lpw_regs #(
   parameter int unsigned     DATA_W  = 32,
   parameter int unsigned     ADDR_W  = 2,
   parameter int unsigned     WIN_W   = 6,
   parameter int unsigned     CODE_W  = 4,
   parameter logic [WIN_W-1:0] WIN_RST = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              en_o,
   output logic [WIN_W-1:0]  win_o,
   output logic [CODE_W-1:0] code_o
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(2);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("lpw_regs: ADDR_W must be at least 2");
   end
   if (WIN_W < CODE_W || DATA_W <= WIN_W) begin : g_bad_width
      $error("lpw_regs: need CODE_W <= WIN_W < DATA_W");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_o   <= 1'b0;
         win_o  <= WIN_RST;
         code_o <= '0;
      end else if (wr_i) begin
         case (addr_i)
            A_CTRL:  en_o   <= wdata_i[0];
            A_WIN:   win_o  <= wdata_i[WIN_W-1:0];
            A_CODE:  code_o <= wdata_i[CODE_W-1:0];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_CTRL:  rdata_o[0]          = en_o;
         A_WIN:   rdata_o[WIN_W-1:0]  = win_o;
         A_CODE:  rdata_o[CODE_W-1:0] = code_o;
         default: ;
      endcase
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata_i[DATA_W-1:WIN_W];

   // R2: upper bits of the read bus stay zero for every address
   p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdata_o[DATA_W-1:WIN_W] == '0);

   // R2: a write to an unmapped address leaves every field unchanged
   p_unmapped_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i != A_CTRL && addr_i != A_WIN && addr_i != A_CODE)
      |=> ($stable(en_o) && $stable(win_o) && $stable(code_o)));

endmodule

// File: rtl/lpw_presc.sv
module lpw_presc #(
   parameter int unsigned CODE_W = 4,
   parameter int unsigned DIV_W  = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o
);

   if (CODE_W != lpw_pkg::CODE_W || DIV_W != lpw_pkg::DIV_W) begin : g_bad_cfg
      $error("lpw_presc: widths must match the divisor table");
   end

   logic [DIV_W-1:0] div;
   logic [DIV_W-1:0] pc;

   assign div    = lpw_pkg::lpw_divisor(code_i);
   assign tick_o = en_i && (pc == div - DIV_W'(1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         pc <= '0;
      else if (!en_i || tick_o)
         pc <= '0;
      else
         pc <= pc + DIV_W'(1);
   end

   // R3: prescale count never reaches the active divisor
   p_presc_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pc < div);

   // R7: disabled prescaler is held at zero
   p_presc_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> pc == '0);

endmodule

// File: rtl/lpw_count.sv
module lpw_count #(
   parameter int unsigned WIN_W  = 6,
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              tick_i,
   input  logic [WIN_W-1:0]  win_i,
   input  logic [CODE_W-1:0] code_i,
   output logic [CODE_W-1:0] code_act_o,
   output logic              wake_o
);

   logic [WIN_W-1:0] cnt;
   logic [WIN_W-1:0] win_act;
   logic [WIN_W-1:0] cnt_nx;
   logic [WIN_W-1:0] win_nx;
   logic             restart;
   logic             load;

   assign restart = tick_i && (cnt == win_act);
   assign load    = !en_i || restart;
   assign cnt_nx  = restart ? '0 : cnt + WIN_W'(1);
   assign win_nx  = load ? win_i : win_act;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         win_act    <= '1;
         code_act_o <= '0;
      end else if (load) begin
         win_act    <= win_i;
         code_act_o <= code_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt    <= '0;
         wake_o <= 1'b0;
      end else begin
         wake_o <= en_i && tick_i && (cnt_nx == win_nx);
         if (!en_i)
            cnt <= '0;
         else if (tick_i)
            cnt <= cnt_nx;
      end
   end

   // R4: the counter never passes the active window
   p_cnt_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt <= win_act);

   // R4: a strobe is only seen while the counter sits on the window
   p_wake_at_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> cnt == win_act);

   // R7: disabling silences the strobe and clears the counter
   p_quiet_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!wake_o && cnt == '0));

   // R6: back-to-back strobes only with a zero window
   p_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |=> (!wake_o || win_act == '0));

endmodule

// File: rtl/lp_wake_timer.sv
module lp_wake_timer #(
   parameter int unsigned      DATA_W  = 32,
   parameter int unsigned      ADDR_W  = 2,
   parameter int unsigned      WIN_W   = 6,
   parameter logic [WIN_W-1:0] WIN_RST = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reg_wr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              wake_o
);

   localparam int unsigned CODE_W = lpw_pkg::CODE_W;
   localparam int unsigned DIV_W  = lpw_pkg::DIV_W;

   if (WIN_W < 1 || WIN_W > 16) begin : g_bad_win
      $error("lp_wake_timer: WIN_W must be 1..16");
   end

   logic              en;
   logic [WIN_W-1:0]  win_reg;
   logic [CODE_W-1:0] code_reg;
   logic [CODE_W-1:0] code_act;
   logic              tick;

   lpw_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .WIN_W  (WIN_W),
      .CODE_W (CODE_W),
      .WIN_RST(WIN_RST)
   ) regs_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (reg_wr_i),
      .addr_i (reg_addr_i),
      .wdata_i(reg_wdata_i),
      .rdata_o(reg_rdata_o),
      .en_o   (en),
      .win_o  (win_reg),
      .code_o (code_reg)
   );

   lpw_presc #(
      .CODE_W(CODE_W),
      .DIV_W (DIV_W)
   ) presc_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en),
      .code_i(code_act),
      .tick_o(tick)
   );

   lpw_count #(
      .WIN_W (WIN_W),
      .CODE_W(CODE_W)
   ) count_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en),
      .tick_i    (tick),
      .win_i     (win_reg),
      .code_i    (code_reg),
      .code_act_o(code_act),
      .wake_o    (wake_o)
   );

   // R7: a strobe always follows an enabled cycle
   p_wake_needs_en_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |-> $past(en));

endmodule

// File: tb/lp_wake_timer_tb.sv
module lp_wake_timer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [1:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        wake;

   int n_chk  = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   lp_wake_timer dut_i (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .reg_wr_i   (wr),
      .reg_addr_i (addr),
      .reg_wdata_i(wdata),
      .reg_rdata_o(rdata),
      .wake_o     (wake)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input int a, input logic [31:0] d);
      wr = 1'b1; addr = a[1:0]; wdata = d;
      @(posedge clk);
      #1 wr = 1'b0;
   endtask

   task automatic reg_read(input int a, output logic [31:0] d);
      addr = a[1:0];
      #1 d = rdata;
   endtask

   task automatic wait_wake(output int n, input int limit);
      n = 0;
      while (1) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (wake) break;
         if (n >= limit) begin
            n = -1;
            break;
         end
      end
   endtask

   task automatic t_reset();
      logic [31:0] d;
      reg_read(0, d); check(d == 0, "R1", "enable after reset", d, 0);
      reg_read(1, d); check(d == 32'h3F, "R1", "window after reset", d, 32'h3F);
      reg_read(2, d); check(d == 0, "R1", "code after reset", d, 0);
      check(wake == 1'b0, "R1", "strobe after reset", wake, 0);
   endtask

   task automatic t_regs();
      logic [31:0] d;
      reg_write(2, 32'hFFFF_FFFF);
      reg_read(2, d); check(d == 32'hF, "R2", "code field masks", d, 32'hF);
      reg_write(1, 32'hFFFF_FFFF);
      reg_read(1, d); check(d == 32'h3F, "R2", "window field masks", d, 32'h3F);
      reg_write(1, 32'hFFFF_FFC0);
      reg_read(1, d); check(d == 0, "R2", "window upper bits ignored", d, 0);
      reg_write(0, 32'hFFFF_FFFE);
      reg_read(0, d); check(d == 0, "R2", "enable only in bit 0", d, 0);
      reg_write(0, 32'hFFFF_FFFF);
      reg_read(0, d); check(d == 1, "R2", "enable readback", d, 1);
      reg_write(0, 0);
      reg_write(3, 32'hFFFF_FFFF);
      reg_read(3, d); check(d == 0, "R2", "unmapped address reads 0", d, 0);
      reg_read(1, d); check(d == 0, "R2", "window untouched by unmapped write", d, 0);
      reg_read(2, d); check(d == 32'hF, "R2", "code untouched by unmapped write", d, 32'hF);
   endtask

   // Measures first and (optionally) second strobe spacing for one code/window.
   task automatic t_period(input int code, input int win, input int div,
                           input bit second, input string req);
      int n;
      int p1;
      int p2;
      p1 = (win == 0) ? div : win * div;
      p2 = (win + 1) * div;
      reg_write(0, 0);
      reg_write(2, code);
      reg_write(1, win);
      reg_write(0, 1);
      wait_wake(n, p1 + 10);
      check(n == p1, req, $sformatf("first strobe code %0d window %0d", code, win), n, p1);
      @(posedge clk);
      @(negedge clk);
      check(wake == 1'b0, "R6", "strobe lasts one cycle", wake, 0);
      if (second) begin
         wait_wake(n, p2 + 10);
         check(n + 1 == p2, req, $sformatf("repeat spacing code %0d window %0d", code, win),
               n + 1, p2);
      end
      reg_write(0, 0);
   endtask

   task automatic t_every_cycle();
      int hi = 0;
      reg_write(2, 0);
      reg_write(1, 0);
      reg_write(0, 1);
      for (int i = 0; i < 6; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (wake) hi++;
      end
      check(hi == 6, "R5", "zero window at divide-by-1 is always high", hi, 6);
      reg_write(0, 0);
   endtask

   task automatic t_disable();
      int n;
      int hi = 0;
      logic [31:0] d;
      reg_write(2, 0);
      reg_write(1, 4);
      reg_write(0, 1);
      repeat (2) @(posedge clk);
      #1;
      reg_write(0, 0);
      for (int i = 0; i < 20; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (wake) hi++;
      end
      check(hi == 0, "R7", "no strobe while disabled", hi, 0);
      reg_read(0, d); check(d == 0, "R7", "enable reads 0", d, 0);
      reg_write(0, 1);
      wait_wake(n, 20);
      check(n == 4, "R7", "full period after re-enable", n, 4);
      reg_write(0, 0);
   endtask

   task automatic t_window_change();
      int n;
      reg_write(2, 0);
      reg_write(1, 3);
      reg_write(0, 1);
      wait_wake(n, 20);
      check(n == 3, "R8", "first strobe before window change", n, 3);
      reg_write(1, 5);
      wait_wake(n, 20);
      check(n == 3, "R8", "old window kept for running period", n, 3);
      wait_wake(n, 20);
      check(n == 6, "R8", "new window after restart", n, 6);
      reg_write(0, 0);
   endtask

   task automatic t_code_change();
      int n;
      reg_write(2, 0);
      reg_write(1, 2);
      reg_write(0, 1);
      wait_wake(n, 20);
      check(n == 2, "R8", "first strobe before code change", n, 2);
      reg_write(2, 2);
      wait_wake(n, 20);
      check(n == 2, "R8", "old divisor kept for running period", n, 2);
      wait_wake(n, 20);
      check(n == 5, "R8", "new divisor after restart", n, 5);
      reg_write(0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_regs();
      t_period(0, 3, 1, 1'b1, "R4");
      t_period(1, 3, 1, 1'b1, "R3");
      t_period(2, 3, 2, 1'b1, "R3");
      t_period(5, 2, 16, 1'b1, "R3");
      t_period(13, 1, 4096, 1'b1, "R3");
      t_period(14, 0, 10240, 1'b1, "R5");
      t_period(15, 1, 61440, 1'b0, "R3");
      t_every_cycle();
      t_disable();
      t_window_change();
      t_code_change();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule